// File: doc/BRIEF.md
# Digit-Serial Binary-Field Multiplier

This block computes the product of two elements of GF(2^M) in polynomial basis, reduced modulo a fixed irreducible polynomial of degree M. Bit i of an operand or of the result is the coefficient of x^i. The field degree M, the digit width D and the low part of the reduction polynomial are parameters. The low part is the polynomial with its x^M term removed, so bit i is the coefficient of x^i.

A caller places both operands on the inputs and pulses `start`. The block captures them and then works through the second operand (the multiplier) D bits per clock, starting with the top digit. In each step the accumulator is multiplied by x^D and reduced. The result is then XORed with one entry of a table that holds all 2^D small-polynomial multiples of the first operand, and the current digit picks the entry. The table is built combinationally from the captured operand with chains of shift-by-one-and-reduce stages, so no extra cycle is spent on it. When M is not a multiple of D, the multiplier is padded with zeros above its top bit. The number of steps therefore depends only on the parameters and never on the operand values.

Top module: `gf2m_digit_mul`

## Requirements
- R1: When `done` is high, `result` equals op_a·op_b mod (x^M + POLY) for the operands captured at the accepted start, for every pair of operand values.
- R2: Digits are taken from the multiplier starting with the most significant one. When M is not a multiple of D, the multiplier is zero-extended at its top to NDIG·D bits, so the product stays exact.
- R3: `done` is high in the cycle that follows the rising clock edge exactly NDIG = ceil(M/D) edges after the edge that accepted `start`, whatever the operand values.
- R4: A `start` sampled while `busy` is low is accepted. `busy` is then high from the next cycle until the cycle in which `done` is high, where it is low again.
- R5: `done` is a single-cycle pulse. `result` then holds its value until the next accepted start.
- R6: A `start` sampled while `busy` is high is ignored. The running product, its operands and its completion cycle are unchanged.
- R7: While reset is high and directly after it, `busy`, `done` and `result` are all zero. Reset is synchronous and active high.
- R8: A digit of value zero only shifts the accumulator. A zero multiplier or a zero multiplicand yields zero, and a multiplier of 1 yields the multiplicand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a product. Taken only when the block is idle |
| op_a | input | M | Multiplicand, polynomial basis |
| op_b | input | M | Multiplier, polynomial basis, consumed D bits per cycle |
| busy | output | 1 | High while digit steps are in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | M | Product of the last accepted operands |

## Verification
The bench builds two small fields side by side. The first is GF(2^5) with x^5+x^2+1 and 2-bit digits, where five bits do not divide into whole digits. Every one of its 1024 operand pairs is swept, which covers the zero-padding of the top digit and every digit pattern. The second is GF(2^8) with x^8+x^4+x^3+x+1 and 4-bit digits. All 256 multiplicands are paired with a spread of multipliers that includes 0, 1 and all ones, so all sixteen table entries are reached. Expected products come from a bit-at-a-time shift-and-add model in the bench. On every operation the bench also measures the latency and the length of the busy window, checks that done lasts one cycle and that the result is held, and repeats start in the middle of some runs.

// File: rtl/gf2m_mul_pkg.sv
package gf2m_mul_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_e;

    typedef struct packed {
        mul_state_e state;
        logic       done;
    } mul_ctrl_t;

    function automatic int digit_count(input int m, input int d);
        return (m + d - 1) / d;
    endfunction

endpackage

// File: rtl/gfm_mulx.sv
module gfm_mulx #(
    parameter int          M    = 163,
    parameter logic [M-1:0] POLY = M'('hC9)
) (
    input  logic [M-1:0] a,
    output logic [M-1:0] y
);
    // multiply by x: shift up one place, fold the carried-out x^M term back
    always_comb begin
        y = {a[M-2:0], 1'b0};
        if (a[M-1]) begin
            y = y ^ POLY;
        end
    end
endmodule

// File: rtl/gfm_shift_reduce.sv
module gfm_shift_reduce #(
    parameter int          M    = 163,
    parameter int          D    = 3,
    parameter logic [M-1:0] POLY = M'('hC9)
) (
    input  logic [M-1:0] p,
    output logic [M-1:0] y
);
    logic [M-1:0] stage [D+1];

    assign stage[0] = p;

    for (genvar j = 0; j < D; j++) begin : g_step
        gfm_mulx #(.M(M), .POLY(POLY)) u_mulx (
            .a (stage[j]),
            .y (stage[j+1])
        );
    end

    assign y = stage[D];
endmodule

// File: rtl/gfm_premult.sv
module gfm_premult #(
    parameter int          M    = 163,
    parameter int          D    = 3,
    parameter logic [M-1:0] POLY = M'('hC9)
) (
    input  logic [M-1:0] a,
    output logic [M-1:0] mult [1<<D]
);
    localparam int NMULT = 1 << D;

    // base[j] = x^j * a mod F
    logic [M-1:0] base [D];

    assign base[0] = a;

    for (genvar j = 1; j < D; j++) begin : g_base
        gfm_mulx #(.M(M), .POLY(POLY)) u_mulx (
            .a (base[j-1]),
            .y (base[j])
        );
    end

    // entry v is the sum of base[j] over the set bits j of v
    always_comb begin
        for (int v = 0; v < NMULT; v++) begin
            mult[v] = '0;
            for (int j = 0; j < D; j++) begin
                if (((v >> j) & 1) == 1) begin
                    mult[v] = mult[v] ^ base[j];
                end
            end
        end
    end
endmodule

// File: rtl/gf2m_digit_mul.sv
module gf2m_digit_mul
    import gf2m_mul_pkg::*;
#(
    parameter int          M    = 163,
    parameter int          D    = 3,
    parameter logic [M-1:0] POLY = M'('hC9)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [M-1:0] op_a,
    input  logic [M-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [M-1:0] result
);
    localparam int NDIG  = digit_count(M, D);
    localparam int PADW  = NDIG * D;
    localparam int CW    = $clog2(NDIG + 1);
    localparam int NMULT = 1 << D;

    mul_ctrl_t        ctrl_q;
    logic [M-1:0]     a_q;
    logic [PADW-1:0]  b_q;
    logic [M-1:0]     acc_q;
    logic [CW-1:0]    left_q;

    logic [M-1:0]     acc_shift;
    logic [M-1:0]     mult [NMULT];
    logic [D-1:0]     digit;

    assign digit = b_q[PADW-1 -: D];

    gfm_premult #(.M(M), .D(D), .POLY(POLY)) u_premult (
        .a    (a_q),
        .mult (mult)
    );

    gfm_shift_reduce #(.M(M), .D(D), .POLY(POLY)) u_shred (
        .p (acc_q),
        .y (acc_shift)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{state: ST_IDLE, done: 1'b0};
            a_q    <= '0;
            b_q    <= '0;
            acc_q  <= '0;
            left_q <= '0;
        end else begin
            ctrl_q.done <= 1'b0;
            case (ctrl_q.state)
                ST_IDLE: begin
                    if (start) begin
                        a_q          <= op_a;
                        b_q          <= PADW'(op_b);
                        acc_q        <= '0;
                        left_q       <= CW'(NDIG);
                        ctrl_q.state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    acc_q  <= acc_shift ^ mult[digit];
                    b_q    <= b_q << D;
                    left_q <= left_q - CW'(1);
                    if (left_q == CW'(1)) begin
                        ctrl_q.state <= ST_IDLE;
                        ctrl_q.done  <= 1'b1;
                    end
                end
                default: ctrl_q.state <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (ctrl_q.state == ST_RUN);
    assign done   = ctrl_q.done;
    assign result = acc_q;

    // independent count of cycles spent running, for the latency check
    logic [CW-1:0] run_len;
    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (!busy && start) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + CW'(1);
        end
    end

    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_len == CW'(NDIG)));

    a_r4_accept: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    a_r4_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result));

    a_r6_ignore_start: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(a_q));

    a_r8_zero_operand: assert property (@(posedge clk) disable iff (rst)
        (busy && a_q == '0) |=> (result == '0));

endmodule

// File: tb/gf2m_digit_mul_test.sv
`timescale 1ns/1ps
module gf2m_digit_mul_test;

    localparam int M1 = 5;
    localparam int D1 = 2;
    localparam int N1 = 3;
    localparam logic [4:0] P1 = 5'b00101;

    localparam int M2 = 8;
    localparam int D2 = 4;
    localparam int N2 = 2;
    localparam logic [7:0] P2 = 8'h1B;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic       st1 = 1'b0;
    logic [4:0] a1 = '0, b1 = '0, r1;
    logic       busy1, done1;

    logic       st2 = 1'b0;
    logic [7:0] a2 = '0, b2 = '0, r2;
    logic       busy2, done2;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gf2m_digit_mul #(.M(M1), .D(D1), .POLY(P1)) uut (
        .clk(clk), .rst(rst), .start(st1), .op_a(a1), .op_b(b1),
        .busy(busy1), .done(done1), .result(r1)
    );

    gf2m_digit_mul #(.M(M2), .D(D2), .POLY(P2)) uut2 (
        .clk(clk), .rst(rst), .start(st2), .op_a(a2), .op_b(b2),
        .busy(busy2), .done(done2), .result(r2)
    );

    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b,
                                           input int m, input logic [7:0] poly);
        logic [7:0] r = '0;
        logic [7:0] mask = 8'((1 << m) - 1);
        for (int i = m - 1; i >= 0; i--) begin
            logic hi = r[m-1];
            r = (r << 1) & mask;
            if (hi) r = r ^ poly;
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic op1(input logic [4:0] a, input logic [4:0] b, input bit interfere);
        logic [7:0] full = ref_mul({3'b0, a}, {3'b0, b}, M1, {3'b0, P1});
        logic [4:0] exp = full[4:0];
        int lat = 0;
        bit busy_ok = 1'b1;
        string tag = (a == 0 || b == 0 || b == 1) ? "R8" : "R2";
        @(negedge clk);
        a1 = a; b1 = b; st1 = 1'b1;
        @(negedge clk);
        st1 = 1'b0;
        if (interfere) begin
            st1 = 1'b1; a1 = ~a; b1 = ~b;   // R6: start while busy
        end
        while (!done1 && lat < 40) begin
            if (!busy1) busy_ok = 1'b0;
            @(negedge clk);
            st1 = 1'b0;
            lat++;
        end
        chk(r1 == exp, interfere ? "R6" : tag, int'(r1), int'(exp));
        chk(lat == N1, "R3", lat, N1);
        chk(busy_ok && !busy1, "R4", int'(busy_ok), 1);
        @(negedge clk);
        chk(!done1 && r1 == exp, "R5", int'(r1), int'(exp));
    endtask

    task automatic op2(input logic [7:0] a, input logic [7:0] b, input bit interfere);
        logic [7:0] exp = ref_mul(a, b, M2, P2);
        int lat = 0;
        bit busy_ok = 1'b1;
        string tag = (a == 0 || b == 0 || b == 1) ? "R8" : "R1";
        @(negedge clk);
        a2 = a; b2 = b; st2 = 1'b1;
        @(negedge clk);
        st2 = 1'b0;
        if (interfere) begin
            st2 = 1'b1; a2 = ~a; b2 = b ^ 8'h5A;   // R6: start while busy
        end
        while (!done2 && lat < 40) begin
            if (!busy2) busy_ok = 1'b0;
            @(negedge clk);
            st2 = 1'b0;
            lat++;
        end
        chk(r2 == exp, interfere ? "R6" : tag, int'(r2), int'(exp));
        chk(lat == N2, "R3", lat, N2);
        chk(busy_ok && !busy2, "R4", int'(busy_ok), 1);
        @(negedge clk);
        chk(!done2 && r2 == exp, "R5", int'(r2), int'(exp));
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R7: state while reset is held
        chk(!busy1 && !done1 && r1 == '0, "R7", int'(r1), 0);
        chk(!busy2 && !done2 && r2 == '0, "R7", int'(r2), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy1 && !done1 && r1 == '0, "R7", int'(r1), 0);
        chk(!busy2 && !done2 && r2 == '0, "R7", int'(r2), 0);

        // R1 R2 R8: every pair in the 5-bit field, 2-bit digits with a padded top digit
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                op1(5'(a), 5'(b), (a == b) && (a % 5 == 1));
            end
        end

        // R1 R8: all multiplicands against a spread of multipliers in the 8-bit field
        for (int a = 0; a < 256; a++) begin
            for (int bi = 0; bi < 37; bi++) begin
                op2(8'(a), 8'(bi * 7), (bi == 5) && (a % 37 == 3));
            end
            op2(8'(a), 8'h01, 1'b0);
            op2(8'(a), 8'hFF, 1'b0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule